// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block holds the power-down state of a small processor core. The core raises a one-cycle sleep strobe when it executes its sleep instruction. The block then enters the sleeping state, turns off the oscillator enable, pulses a clear to the watchdog counter (which keeps counting) and updates two status bits. The first bit, power-down, drops when sleep really happens. The second bit, time-out, drops when a watchdog expiry ends the sleep. Software reads both bits after it resumes to learn why it is running again.

Three things end sleep. An active-low external reset gives a full device reset. An expired watchdog, if it is enabled, wakes the core and clears the time-out bit. An interrupt source whose flag and enable are both set also wakes the core, whatever the global interrupt enable says. On a wake the block gives a one-cycle wake strobe, and the core goes on with the instruction that was already fetched. If the global enable was set, the block raises a one-cycle vector request one cycle later, and the core then branches to the interrupt address 0x0004.

An enabled interrupt that is already pending in the cycle of the sleep strobe turns that sleep into a no-op. A clear-watchdog command, taken only while awake, sets both status bits and pulses the watchdog clear. All signals are plain control and status levels or strobes. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After power-on reset (rst_n low): asleep=0, osc_en=1, pd_bit=1, to_bit=1, and wdt_clr, dev_rst, wake, vec_req are all 0.
- R2: A sleep_req while awake, with no source having both irq_flag[i] and irq_en[i] set in that cycle, gives in the next cycle asleep=1, osc_en=0, pd_bit=0, to_bit=1 and a wdt_clr pulse of exactly one cycle.
- R3: A sleep_req in a cycle where some irq_flag[i] & irq_en[i] is 1 is a no-op: asleep stays 0, pd_bit and to_bit keep their values, and wdt_clr stays 0.
- R4: While ext_rst_n is 0, dev_rst is 1 from the next cycle on, and the block is awake (asleep=0, osc_en=1). pd_bit and to_bit keep their values, wake stays 0 and sleep_req is ignored. dev_rst returns to 0 one cycle after ext_rst_n returns to 1.
- R5: While asleep, wdt_timeout=1 with wdt_en=1 gives in the next cycle wake=1 for one cycle, asleep=0, osc_en=1 and to_bit=0. No vec_req follows.
- R6: While asleep, wdt_timeout with wdt_en=0 has no effect: the block stays asleep.
- R7: While asleep, any source with irq_flag[i] & irq_en[i] gives in the next cycle wake=1 for one cycle, asleep=0 and osc_en=1, for either value of gie. pd_bit stays 0 and to_bit stays 1.
- R8: A flag whose enable bit is 0 neither wakes the block nor blocks sleep entry.
- R9: After an interrupt wake, vec_req is 1 for exactly one cycle, the cycle after wake, if gie was 1 in the cycle the wake condition was seen. Otherwise vec_req stays 0.
- R10: A clrwdt_req while awake (and without sleep_req) gives in the next cycle pd_bit=1, to_bit=1 and a one-cycle wdt_clr pulse.
- R11: While asleep, sleep_req and clrwdt_req have no effect: no wdt_clr pulse, and the status bits are unchanged.
- R12: If the watchdog wake condition and an interrupt wake condition occur in the same sleeping cycle, the watchdog wins: to_bit=0 and no vec_req.
- R13: An enabled interrupt that first appears in the cycle after the sleep strobe lets the sleep complete (pd_bit=0, to_bit=1, wdt_clr pulse), and the wake follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-on reset, active low |
| sleep_req | input | 1 | One-cycle strobe: sleep instruction executed |
| clrwdt_req | input | 1 | One-cycle strobe: clear-watchdog instruction executed |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| wdt_en | input | 1 | Watchdog enabled |
| irq_flag | input | N_IRQ | Per-source interrupt flags |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| asleep | output | 1 | Core is in the sleeping state |
| osc_en | output | 1 | Oscillator driver enable |
| wdt_clr | output | 1 | One-cycle watchdog clear pulse |
| pd_bit | output | 1 | Power-down status bit |
| to_bit | output | 1 | Time-out status bit |
| dev_rst | output | 1 | Full device reset |
| wake | output | 1 | One-cycle wake strobe |
| vec_req | output | 1 | One-cycle request to branch to 0x0004 |

## Verification
Every result appears one cycle after the input cycle that causes it: state, status bits, wake, wdt_clr and dev_rst. The only exception is vec_req, which comes two cycles after the interrupt wake condition, so one cycle after wake. The driver applies each stimulus on the falling edge and queues the expected full output word, tagged with the cycle in which it is due. The monitor compares that word on the falling edge of that cycle, so the two-cycle vector result is checked by the item queued with the following step. Any item the monitor has not compared by its due cycle counts as a failure.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } pd_state_e;

  typedef struct packed {
    logic enter_sleep;
    logic wdt_wake;
    logic irq_wake;
    logic clr_cmd;
  } pd_evt_t;

endpackage

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             pending
);
  localparam int LAST = N_IRQ - 1;

  logic [N_IRQ-1:0] hit;
  logic [N_IRQ-1:0] acc;

  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_src
      assign hit[g] = irq_flag[g] & irq_en[g];
      if (g == 0) begin : g_first
        assign acc[g] = hit[g];
      end else begin : g_rest
        assign acc[g] = acc[g-1] | hit[g];
      end
    end
  endgenerate

  assign pending = acc[LAST];

  always_comb begin
    // R8: a masked flag alone never raises the pending condition
    a_r8_masked: assert ((irq_en != '0) || !pending);
  end
endmodule

// File: rtl/status_bits.sv
module status_bits
  import pwrdn_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pd_evt_t evt,
  output logic    pd_bit,
  output logic    to_bit
);
  logic pd_q, to_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b1;
      to_q <= 1'b1;
    end else begin
      if (evt.clr_cmd) begin
        pd_q <= 1'b1;
        to_q <= 1'b1;
      end else if (evt.enter_sleep) begin
        pd_q <= 1'b0;
        to_q <= 1'b1;
      end else if (evt.wdt_wake) begin
        to_q <= 1'b0;
      end
    end
  end

  assign pd_bit = pd_q;
  assign to_bit = to_q;

  a_r2_pd_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_q) |-> $past(evt.enter_sleep));

  a_r5_to_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(to_q) |-> $past(evt.wdt_wake));
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import pwrdn_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sleep_req,
  input  logic    clrwdt_req,
  input  logic    ext_rst_n,
  input  logic    wdt_timeout,
  input  logic    wdt_en,
  input  logic    pending,
  input  logic    gie,
  output pd_evt_t evt,
  output logic    asleep,
  output logic    wdt_clr,
  output logic    dev_rst,
  output logic    wake,
  output logic    vec_req
);
  pd_state_e st_q, st_d;
  logic      wdt_clr_q, dev_rst_q, wake_q, vec_pend_q, vec_req_q;
  logic      in_run, in_sleep, ext_ok;

  assign in_run   = (st_q == ST_RUN);
  assign in_sleep = (st_q == ST_SLEEP);
  assign ext_ok   = ext_rst_n;

  always_comb begin
    evt             = '0;
    evt.enter_sleep = in_run & ext_ok & sleep_req & ~pending;
    evt.clr_cmd     = in_run & ext_ok & clrwdt_req & ~sleep_req;
    evt.wdt_wake    = in_sleep & ext_ok & wdt_en & wdt_timeout;
    evt.irq_wake    = in_sleep & ext_ok & ~evt.wdt_wake & pending;
  end

  always_comb begin
    st_d = st_q;
    if (!ext_ok)                            st_d = ST_RUN;
    else if (evt.enter_sleep)               st_d = ST_SLEEP;
    else if (evt.wdt_wake || evt.irq_wake)  st_d = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      wdt_clr_q  <= 1'b0;
      dev_rst_q  <= 1'b0;
      wake_q     <= 1'b0;
      vec_pend_q <= 1'b0;
      vec_req_q  <= 1'b0;
    end else begin
      st_q       <= st_d;
      wdt_clr_q  <= evt.enter_sleep | evt.clr_cmd;
      dev_rst_q  <= ~ext_ok;
      wake_q     <= evt.wdt_wake | evt.irq_wake;
      vec_pend_q <= evt.irq_wake & gie;
      vec_req_q  <= vec_pend_q & ext_ok;
    end
  end

  assign asleep  = in_sleep;
  assign wdt_clr = wdt_clr_q;
  assign dev_rst = dev_rst_q;
  assign wake    = wake_q;
  assign vec_req = vec_req_q;

  a_r3_noop_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && ext_rst_n && sleep_req && pending) |=> (st_q == ST_RUN));

  a_r4_rst_awake: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_q |-> (st_q == ST_RUN && !wake_q));

  a_r7_wake_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> $past(st_q == ST_SLEEP));

  a_r9_vec_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_q |-> $past(wake_q));

  a_r11_clr_only_awake: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr_q |-> $past(st_q == ST_RUN));
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             clrwdt_req,
  input  logic             ext_rst_n,
  input  logic             wdt_timeout,
  input  logic             wdt_en,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  output logic             asleep,
  output logic             osc_en,
  output logic             wdt_clr,
  output logic             pd_bit,
  output logic             to_bit,
  output logic             dev_rst,
  output logic             wake,
  output logic             vec_req
);
  logic    pending;
  pd_evt_t evt;

  irq_sense #(.N_IRQ(N_IRQ)) u_sense (
    .irq_flag (irq_flag),
    .irq_en   (irq_en),
    .pending  (pending)
  );

  sleep_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .clrwdt_req  (clrwdt_req),
    .ext_rst_n   (ext_rst_n),
    .wdt_timeout (wdt_timeout),
    .wdt_en      (wdt_en),
    .pending     (pending),
    .gie         (gie),
    .evt         (evt),
    .asleep      (asleep),
    .wdt_clr     (wdt_clr),
    .dev_rst     (dev_rst),
    .wake        (wake),
    .vec_req     (vec_req)
  );

  status_bits u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .pd_bit (pd_bit),
    .to_bit (to_bit)
  );

  assign osc_en = ~asleep;

  a_r12_wdt_first: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && ext_rst_n && wdt_en && wdt_timeout) |=> (!to_bit && !vec_req));
endmodule

// File: tb/tb_pwrdn_ctrl.sv
module tb_pwrdn_ctrl;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 0, clrwdt_req = 0, ext_rst_n = 1, wdt_timeout = 0, wdt_en = 0, gie = 0;
  logic [NI-1:0] irq_flag = '0, irq_en = '0;
  logic asleep, osc_en, wdt_clr, pd_bit, to_bit, dev_rst, wake, vec_req;

  always #5 clk = ~clk;

  pwrdn_ctrl #(.N_IRQ(NI)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .clrwdt_req(clrwdt_req),
    .ext_rst_n(ext_rst_n), .wdt_timeout(wdt_timeout), .wdt_en(wdt_en),
    .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
    .asleep(asleep), .osc_en(osc_en), .wdt_clr(wdt_clr), .pd_bit(pd_bit),
    .to_bit(to_bit), .dev_rst(dev_rst), .wake(wake), .vec_req(vec_req)
  );

  typedef struct {
    int         due;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // order: asleep osc_en wdt_clr pd to dev_rst wake vec_req
  function automatic logic [7:0] mk(bit a, bit o, bit c, bit p, bit t, bit r, bit w, bit v);
    return {a, o, c, p, t, r, w, v};
  endfunction

  // monitor: pops items on their due cycle
  always @(negedge clk) begin
    logic [7:0] got;
    got = {asleep, osc_en, wdt_clr, pd_bit, to_bit, dev_rst, wake, vec_req};
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (it.due < cyc) begin
        n_bad++;
        $display("FAIL %s: item missed its cycle %0d (now %0d) exp %b", it.tag, it.due, cyc, it.exp);
      end else if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %b exp %b (cycle %0d)", it.tag, got, it.exp, cyc);
      end
    end
  end

  task automatic step(bit sl, bit cw, bit er, bit wt, bit we,
                      logic [NI-1:0] fl, logic [NI-1:0] en, bit g,
                      logic [7:0] exp, string tag);
    item_t it;
    @(negedge clk);
    sleep_req = sl; clrwdt_req = cw; ext_rst_n = er; wdt_timeout = wt;
    wdt_en = we; irq_flag = fl; irq_en = en; gie = g;
    it.due = cyc + 1; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(logic [7:0] exp, string tag);
    step(0, 0, 1, 0, 0, '0, '0, 0, exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(mk(0,1,0,1,1,0,0,0), "R1 reset state");
    step(1,0,1,0,0, 4'b0000, 4'b0000, 0, mk(1,0,1,0,1,0,0,0), "R2 sleep entry");
    idle(mk(1,0,0,0,1,0,0,0), "R2 clear pulse one cycle");
    step(1,0,1,0,0, 4'b0000, 4'b0000, 0, mk(1,0,0,0,1,0,0,0), "R11 sleep_req while asleep");
    step(0,1,1,0,0, 4'b0000, 4'b0000, 0, mk(1,0,0,0,1,0,0,0), "R11 clrwdt while asleep");
    step(0,0,1,1,0, 4'b0000, 4'b0000, 0, mk(1,0,0,0,1,0,0,0), "R6 disabled timeout");
    step(0,0,1,0,0, 4'b0001, 4'b0000, 1, mk(1,0,0,0,1,0,0,0), "R8 masked flag no wake");
    step(0,0,1,1,1, 4'b0000, 4'b0000, 0, mk(0,1,0,0,0,0,1,0), "R5 watchdog wake");
    idle(mk(0,1,0,0,0,0,0,0), "R5 no vector after watchdog wake");
    step(0,1,1,0,0, 4'b0000, 4'b0000, 0, mk(0,1,1,1,1,0,0,0), "R10 clear command");
    idle(mk(0,1,0,1,1,0,0,0), "R10 pulse ends");
    step(1,0,1,0,0, 4'b0010, 4'b0010, 0, mk(0,1,0,1,1,0,0,0), "R3 pending makes sleep no-op");
    step(1,0,1,0,0, 4'b0100, 4'b0000, 1, mk(1,0,1,0,1,0,0,0), "R8 masked flag allows sleep");
    step(0,0,1,0,0, 4'b0100, 4'b0100, 0, mk(0,1,0,0,1,0,1,0), "R7 interrupt wake gie=0");
    idle(mk(0,1,0,0,1,0,0,0), "R9 no vector when gie=0");
    step(1,0,1,0,0, 4'b0000, 4'b0000, 0, mk(1,0,1,0,1,0,0,0), "R2 sleep entry again");
    step(0,0,1,0,0, 4'b1000, 4'b1000, 1, mk(0,1,0,0,1,0,1,0), "R7 interrupt wake gie=1");
    idle(mk(0,1,0,0,1,0,0,1), "R9 vector one cycle after wake");
    idle(mk(0,1,0,0,1,0,0,0), "R9 vector one cycle only");
    step(1,0,1,0,0, 4'b0000, 4'b0000, 0, mk(1,0,1,0,1,0,0,0), "R12 sleep before race");
    step(0,0,1,1,1, 4'b0001, 4'b0001, 1, mk(0,1,0,0,0,0,1,0), "R12 watchdog wins");
    idle(mk(0,1,0,0,0,0,0,0), "R12 no vector");
    step(1,0,1,0,0, 4'b0000, 4'b0000, 0, mk(1,0,1,0,1,0,0,0), "R4 sleep before reset");
    step(0,0,0,0,0, 4'b0000, 4'b0000, 0, mk(0,1,0,0,1,1,0,0), "R4 external reset in sleep");
    step(1,0,0,0,0, 4'b0000, 4'b0000, 0, mk(0,1,0,0,1,1,0,0), "R4 sleep ignored in reset");
    idle(mk(0,1,0,0,1,0,0,0), "R4 reset released");
    step(1,0,1,0,0, 4'b0000, 4'b0000, 0, mk(1,0,1,0,1,0,0,0), "R13 sleep completes");
    step(0,0,1,0,0, 4'b0010, 4'b0010, 0, mk(0,1,0,0,1,0,1,0), "R13 late interrupt wakes");
    idle(mk(0,1,0,0,1,0,0,0), "R13 settled");
    step(0,1,1,0,0, 4'b0000, 4'b0000, 0, mk(0,1,1,1,1,0,0,0), "R10 clear restores bits");
    idle(mk(0,1,0,1,1,0,0,0), "R10 final");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R1: %0d items left unchecked exp 0", q.size());
    end
    finish_run();
  end
endmodule